// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column address for each beat of an SDRAM burst. A start strobe captures a 10-bit starting column, a burst length code and an order select. From the next cycle the block presents the column of the current beat together with a beat-valid flag. Each advance strobe moves it on to the following beat.

The block supports three orders:
- **Sequential:** the low bits of the column count up and wrap inside the aligned block of the burst length.
- **Interleaved:** the low bits are the starting column's low bits XORed with the beat index.
- **Full page:** the whole column counts up, wraps from 1023 to 0, and runs until a burst stop or a new start.

A done flag marks the final beat. A burst-stop input ends the sequence on the cycle it is applied. A start strobe is accepted on any clock, so a new burst can follow the final beat of the previous one with no idle cycle. It also cuts off a burst that is still running.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it is released with no start strobe, `beatValid` and `done` are 0.
- R2: In the cycle after a clock edge that samples `startStb` high, `beatValid` is 1 and `colOut` equals the sampled `startCol`.
- R3: With `lenCode` 0, 1, 2 or 3 (length L = 1, 2, 4 or 8) and `interleave` 0, beat k shows the column (S & ~(L-1)) | ((S + k) & (L-1)), where S is the start column. Bits above the low log2(L) bits stay fixed for the whole burst.
- R4: With `lenCode` 0 to 3 and `interleave` 1, beat k shows the column (S & ~(L-1)) | ((S ^ k) & (L-1)).
- R5: Any `lenCode` with bit 2 set (4 to 7) selects full page. Beat k then shows (S + k) mod 1024 whatever the value of `interleave`, and `done` stays 0 unless `burstStop` is high.
- R6: For lengths 1 to 8, `done` is 1 exactly while the beat with index L-1 is shown. With length 1 this is the first beat.
- R7: An advance sampled on the final beat with no start strobe makes `beatValid` 0 from the next cycle.
- R8: `burstStop` high during a valid beat makes `done` 1 in that same cycle and `beatValid` 0 from the next cycle, unless a start strobe is sampled at the same edge.
- R9: A start strobe sampled during a running burst, including on its final beat, restarts the sequence at the new column in the next cycle with no invalid cycle between.
- R10: While `advance`, `burstStop` and `startStb` are low, a valid beat holds: `colOut` and `beatValid` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| startStb | input | 1 | Captures the start column, length and order, and begins a burst |
| startCol | input | 10 | Starting column |
| lenCode | input | 3 | Burst length code: 0 to 3 select 2^code beats; 4 to 7 select full page |
| interleave | input | 1 | 1 selects interleaved order, 0 selects sequential; ignored in full page |
| advance | input | 1 | Moves on to the next beat |
| burstStop | input | 1 | Ends the running burst |
| colOut | output | 10 | Column of the current beat |
| beatValid | output | 1 | The current beat is valid |
| done | output | 1 | The current beat is the final one |

## Verification
The bench builds the block with its default 10-bit column and 3-bit length code. This small configuration lets it sweep every one of the 1024 start columns through every fixed length in both orders. As a result, every wrap point inside an aligned block and every setting of the upper bits is seen. Full-page bursts run past the 1023-to-0 wrap with both order settings and two full-page codes. Directed cases cover hold, burst stop, restart in mid-burst and back-to-back bursts.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef struct packed {
    logic load;
    logic step;
  } seqStrobe_t;
endpackage

// File: rtl/bcs_datapath.sv
module bcs_datapath
  import bcs_pkg::*;
#(
  parameter int COL_W = 10,
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [COL_W-1:0] startCol,
  input  logic [LEN_W-1:0] lenCode,
  input  logic             interleave,
  output logic [COL_W-1:0] colOut,
  output logic             lastBeat
);
  localparam int FULL_BIT = LEN_W - 1;
  localparam logic [COL_W-1:0] ONE = COL_W'(1);

  logic [COL_W-1:0] baseCol;
  logic [COL_W-1:0] beatIdx;
  logic [COL_W-1:0] lowMask;
  logic             ilvMode;
  logic             fullPage;
  logic [COL_W-1:0] lowBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseCol  <= '0;
      beatIdx  <= '0;
      lowMask  <= '0;
      ilvMode  <= 1'b0;
      fullPage <= 1'b0;
    end else if (strobe.load) begin
      baseCol  <= startCol;
      beatIdx  <= '0;
      fullPage <= lenCode[FULL_BIT];
      ilvMode  <= interleave & ~lenCode[FULL_BIT];
      if (lenCode[FULL_BIT]) lowMask <= '1;
      else lowMask <= (ONE << lenCode[FULL_BIT-1:0]) - ONE;
    end else if (strobe.step) begin
      beatIdx <= beatIdx + ONE;
    end
  end

  always_comb begin
    lowBits  = ilvMode ? (baseCol ^ beatIdx) : (baseCol + beatIdx);
    colOut   = (baseCol & ~lowMask) | (lowBits & lowMask);
    lastBeat = ~fullPage & (beatIdx == lowMask);
  end

  assert_first_col_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> colOut == $past(startCol));

  assert_upper_fixed_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !strobe.load && !fullPage) |=>
      (colOut & ~lowMask) == $past(colOut & ~lowMask));

  assert_full_inc_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !strobe.load && fullPage) |=> colOut == $past(colOut) + ONE);

  assert_hold_col_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.step && !strobe.load) |=> $stable(colOut));
endmodule

// File: rtl/bcs_control.sv
module bcs_control
  import bcs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startStb,
  input  logic       advance,
  input  logic       burstStop,
  input  logic       lastBeat,
  output seqStrobe_t strobe,
  output logic       beatValid,
  output logic       done
);
  logic active;
  logic endNow;

  always_comb begin
    endNow      = active & (burstStop | (advance & lastBeat));
    strobe.load = startStb;
    strobe.step = active & advance & ~lastBeat & ~burstStop & ~startStb;
    beatValid   = active;
    done        = active & (burstStop | lastBeat);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) active <= 1'b0;
    else if (startStb) active <= 1'b1;
    else if (endNow) active <= 1'b0;
  end

  assert_start_valid_R9: assert property (@(posedge clk) disable iff (!rstN)
    startStb |=> beatValid);

  assert_last_ends_R7: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && advance && lastBeat && !startStb) |=> !beatValid);

  assert_stop_ends_R8: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && burstStop && !startStb) |=> !beatValid);

  assert_done_in_burst_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> beatValid);

  assert_hold_valid_R10: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && !advance && !burstStop && !startStb) |=> beatValid);
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int COL_W = 10,
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startStb,
  input  logic [COL_W-1:0] startCol,
  input  logic [LEN_W-1:0] lenCode,
  input  logic             interleave,
  input  logic             advance,
  input  logic             burstStop,
  output logic [COL_W-1:0] colOut,
  output logic             beatValid,
  output logic             done
);
  seqStrobe_t strobe;
  logic       lastBeat;

  bcs_control uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .startStb  (startStb),
    .advance   (advance),
    .burstStop (burstStop),
    .lastBeat  (lastBeat),
    .strobe    (strobe),
    .beatValid (beatValid),
    .done      (done)
  );

  bcs_datapath #(.COL_W(COL_W), .LEN_W(LEN_W)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .startCol   (startCol),
    .lenCode    (lenCode),
    .interleave (interleave),
    .colOut     (colOut),
    .lastBeat   (lastBeat)
  );

  assert_reset_idle_R1: assert property (@(posedge clk) !rstN |=> !beatValid || $past(startStb));
endmodule

// File: tb/sim_burst_col_seq.sv
module sim_burst_col_seq;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startStb = 1'b0;
  logic [9:0] startCol = '0;
  logic [2:0] lenCode = '0;
  logic       interleave = 1'b0;
  logic       advance = 1'b0;
  logic       burstStop = 1'b0;
  logic [9:0] colOut;
  logic       beatValid;
  logic       done;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  burst_col_seq u0 (
    .clk(clk), .rstN(rstN), .startStb(startStb), .startCol(startCol),
    .lenCode(lenCode), .interleave(interleave), .advance(advance),
    .burstStop(burstStop), .colOut(colOut), .beatValid(beatValid), .done(done)
  );

  function automatic int expCol(int s, int code, bit ilv, int k);
    int m;
    if (code >= 4) return (s + k) % 1024;
    m = (1 << code) - 1;
    if (ilv) return (s & ~m & 1023) | ((s ^ k) & m);
    return (s & ~m & 1023) | ((s + k) & m);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic begin_burst(int s, int code, bit ilv);
    @(negedge clk);
    startStb = 1'b1; startCol = 10'(s); lenCode = 3'(code);
    interleave = ilv; advance = 1'b0; burstStop = 1'b0;
    @(negedge clk);
    startStb = 1'b0;
  endtask

  task automatic sweep_burst(int s, int code, bit ilv);
    int len;
    len = 1 << code;
    begin_burst(s, code, ilv);
    advance = 1'b1;
    for (int k = 0; k < len; k++) begin
      #1;
      chk(ilv ? "R4 col" : "R3 col", colOut, expCol(s, code, ilv, k));
      chk("R6 done", done, (k == len - 1));
      if (k == 0) chk("R2 valid", beatValid, 1);
      @(negedge clk);
    end
    advance = 1'b0;
    chk("R7 valid after last", beatValid, 0);
  endtask

  initial begin
    #1;
    chk("R1 valid in reset", beatValid, 0);
    chk("R1 done in reset", done, 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", beatValid, 0);
    chk("R1 done after reset", done, 0);

    // R3 R4 R6 R7: all start columns, fixed lengths, both orders
    for (int code = 0; code < 4; code++)
      for (int ilv = 0; ilv < 2; ilv++)
        for (int s = 0; s < 1024; s++)
          sweep_burst(s, code, bit'(ilv));

    // R5: full page across wrap, interleave ignored, then R8 stop
    for (int v = 0; v < 2; v++) begin
      begin_burst(1020 - v, 4 + 3 * v, bit'(v));
      advance = 1'b1;
      for (int k = 0; k < 1030; k++) begin
        #1;
        chk("R5 full col", colOut, (1020 - v + k) % 1024);
        chk("R5 full done", done, 0);
        @(negedge clk);
      end
      burstStop = 1'b1;
      #1;
      chk("R8 done on stop", done, 1);
      chk("R8 valid on stop", beatValid, 1);
      @(negedge clk);
      burstStop = 1'b0; advance = 1'b0;
      chk("R8 ended after stop", beatValid, 0);
    end

    // R10: hold without advance
    begin_burst(37, 3, 1'b0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R10 hold col", colOut, 37);
      chk("R10 hold valid", beatValid, 1);
    end

    // R8: stop in mid-burst of length 8
    advance = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 pre-stop col", colOut, expCol(37, 3, 0, 2));
    burstStop = 1'b1; advance = 1'b0;
    #1;
    chk("R8 done mid", done, 1);
    @(negedge clk);
    burstStop = 1'b0;
    chk("R8 valid mid", beatValid, 0);

    // R9: restart in mid-burst
    begin_burst(100, 3, 1'b1);
    advance = 1'b1;
    @(negedge clk);
    @(negedge clk);
    startStb = 1'b1; startCol = 10'd513; lenCode = 3'd1; interleave = 1'b0;
    @(negedge clk);
    startStb = 1'b0;
    #1;
    chk("R9 restart valid", beatValid, 1);
    chk("R9 restart col", colOut, 513);
    @(negedge clk);
    chk("R9 second beat", colOut, expCol(513, 1, 0, 1));
    chk("R6 done len2", done, 1);
    // R9: back-to-back on final beat
    startStb = 1'b1; startCol = 10'd6; lenCode = 3'd2; interleave = 1'b1;
    @(negedge clk);
    startStb = 1'b0;
    #1;
    chk("R9 b2b valid", beatValid, 1);
    chk("R9 b2b col", colOut, 6);
    @(negedge clk);
    chk("R4 b2b beat1", colOut, expCol(6, 2, 1, 1));
    advance = 1'b0;
    @(negedge clk);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule